// File: doc/BRIEF.md
# Counter-Polled Bus Arbiter

This block decides which of several devices gets a shared bus. All devices drive one common request line, so the arbiter only knows that someone is asking, not who. To find out, it broadcasts a device number on its poll-address output, one number per clock cycle. A device that sees its own number while it is asking answers on the shared busy line. The arbiter then stops counting, grants the bus to that number, and keeps the grant until the device lets busy fall.

Each search begins at a start point chosen by a two-bit mode input. Fixed mode always begins at device 0. Rotating mode begins at the device after the most recent winner, which gives cyclic priority. Programmed mode begins at a value written through a load-enable port, so any device can be put first. The count wraps from the last device back to 0. If no device answers in a full sweep of all devices, the round ends and the arbiter goes back to idle.

Top module: `pollarb`

## Requirements
- R1: After a synchronous reset, `polling_o` and `grant_o` are low and `poll_addr_o` is 0.
- R2: When the arbiter is idle (neither polling nor granting) and `bus_req_i` is high at a clock edge, `polling_o` is high in the following cycle. With `bus_req_i` low it stays idle.
- R3: With `mode_i` = 0 (fixed) or 3 (treated as fixed), the first address polled in a round is 0.
- R4: With `mode_i` = 1 (rotating), the first address polled is the one after the last granted device, modulo N_DEV. After reset the last granted device counts as N_DEV-1, so the first rotating round starts at 0. A round that finds no device leaves this unchanged.
- R5: With `mode_i` = 2 (programmed), the first address polled is the stored start value. A pulse on `start_ld_i` stores `start_val_i`. Values of N_DEV or more are stored as 0. The stored value is used from the next round on.
- R6: In each poll cycle where `busy_i` is low, the next polled address is the current one plus 1, and N_DEV-1 is followed by 0.
- R7: If `busy_i` is high in a poll cycle, then in the next cycle `grant_o` is high, `polling_o` is low and `owner_o` equals the address that was polled. `poll_addr_o` then holds steady while the grant lasts.
- R8: `grant_o` stays high as long as `busy_i` stays high. In the cycle after `busy_i` is seen low during a grant, both `grant_o` and `polling_o` are low.
- R9: A round in which no poll cycle sees `busy_i` lasts exactly N_DEV poll cycles and then returns to idle.
- R10: `busy_i` seen while idle never produces a grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_req_i | input | 1 | Shared request line: some device wants the bus |
| busy_i | input | 1 | Shared busy line: the device at the polled number is answering, or the granted device is still using the bus |
| mode_i | input | 2 | Start-point mode: 0 fixed, 1 rotating, 2 programmed, 3 fixed |
| start_ld_i | input | 1 | Load strobe for the programmed start value |
| start_val_i | input | ID_W | Programmed start value |
| poll_addr_o | output | ID_W | Device number being polled, held at the owner while granted |
| polling_o | output | 1 | High in each poll cycle |
| grant_o | output | 1 | Bus granted to `owner_o` |
| owner_o | output | ID_W | Number of the most recently granted device |

## Verification
The assertions check the cycle-level handshake on every cycle: the launch from idle, the step from one address to the next with wrap, the capture of the polled address on busy, the frozen address and held grant, the release back to idle, the cap on round length, and that the arbiter never grants from idle. Only the bench scenarios can show which address a round begins at under each mode. These cover rotation after several winners, a programmed value that is out of range, rounds in which no device answers, and which device actually wins for a given set of requesters. All of these depend on history that one cycle does not show.

// File: rtl/pollarb_pkg.sv
package pollarb_pkg;

    // Start-point selection for each arbitration round
    typedef enum logic [1:0] {
        MODE_FIXED  = 2'd0,
        MODE_ROTATE = 2'd1,
        MODE_PROG   = 2'd2,
        MODE_RSVD   = 2'd3
    } start_mode_e;

    // Arbiter phase
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_POLL  = 2'd1,
        ST_GRANT = 2'd2
    } arb_state_e;

    // Per-cycle commands from the controller to the datapath
    typedef struct packed {
        logic launch;   // load the start point into the poll counter
        logic advance;  // step the poll counter to the next device
        logic hit;      // capture the polled device as the winner
    } ctrl_cmd_t;

    // Increment modulo n
    function automatic int unsigned wrap_next(int unsigned v, int unsigned n);
        return (v + 1 >= n) ? 0 : v + 1;
    endfunction

endpackage

// File: rtl/pollarb_start_sel.sv
module pollarb_start_sel
    import pollarb_pkg::*;
#(
    parameter int unsigned N_DEV = 6,
    parameter int unsigned ID_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  start_mode_e       mode,
    input  logic              ld,
    input  logic [ID_W-1:0]   ld_val,
    input  logic              win_capture,
    input  logic [ID_W-1:0]   win_id,
    output logic [ID_W-1:0]   start_id,
    output logic [ID_W-1:0]   last_win
);

    localparam logic [ID_W-1:0] LAST_ID = ID_W'(N_DEV - 1);

    logic [ID_W-1:0] prog_q;
    logic [ID_W-1:0] last_q;
    logic [ID_W-1:0] rot_start;

    // Programmed start register; out-of-range values fold to 0
    always_ff @(posedge clk) begin
        if (rst) begin
            prog_q <= '0;
        end else if (ld) begin
            prog_q <= (32'(ld_val) < N_DEV) ? ld_val : '0;
        end
    end

    // Most recent winner; reset so that rotation begins at device 0
    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= LAST_ID;
        end else if (win_capture) begin
            last_q <= win_id;
        end
    end

    assign rot_start = ID_W'(wrap_next(32'(last_q), N_DEV));

    always_comb begin
        unique case (mode)
            MODE_ROTATE: start_id = rot_start;
            MODE_PROG:   start_id = prog_q;
            default:     start_id = '0;
        endcase
    end

    assign last_win = last_q;

endmodule

// File: rtl/pollarb_counter.sv
module pollarb_counter
    import pollarb_pkg::*;
#(
    parameter int unsigned N_DEV = 6,
    parameter int unsigned ID_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  logic              advance,
    input  logic [ID_W-1:0]   start_id,
    output logic [ID_W-1:0]   cnt,
    output logic              last_step
);

    localparam int unsigned STEP_W = (N_DEV > 1) ? $clog2(N_DEV) : 1;
    localparam logic [STEP_W-1:0] FINAL_STEP = STEP_W'(N_DEV - 1);

    logic [ID_W-1:0]   cnt_q;
    logic [STEP_W-1:0] step_q;

    // The poll counter walks one device per cycle.
    // The step counter tracks how many devices this round has covered.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            step_q <= '0;
        end else if (launch) begin
            cnt_q  <= start_id;
            step_q <= '0;
        end else if (advance) begin
            cnt_q  <= ID_W'(wrap_next(32'(cnt_q), N_DEV));
            step_q <= step_q + STEP_W'(1);
        end
    end

    assign cnt       = cnt_q;
    assign last_step = (step_q == FINAL_STEP);

endmodule

// File: rtl/pollarb_ctrl.sv
module pollarb_ctrl
    import pollarb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_req,
    input  logic        busy,
    input  logic        last_step,
    output ctrl_cmd_t   cmd,
    output arb_state_e  state
);

    arb_state_e state_q;
    arb_state_e state_d;

    always_comb begin
        state_d     = state_q;
        cmd         = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (bus_req) begin
                    cmd.launch = 1'b1;
                    state_d    = ST_POLL;
                end
            end
            ST_POLL: begin
                if (busy) begin
                    cmd.hit = 1'b1;
                    state_d = ST_GRANT;
                end else if (last_step) begin
                    state_d = ST_IDLE;
                end else begin
                    cmd.advance = 1'b1;
                end
            end
            ST_GRANT: begin
                if (!busy) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign state = state_q;

endmodule

// File: rtl/pollarb.sv
module pollarb
    import pollarb_pkg::*;
#(
    parameter int unsigned N_DEV = 6,
    parameter int unsigned ID_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req_i,
    input  logic              busy_i,
    input  logic [1:0]        mode_i,
    input  logic              start_ld_i,
    input  logic [ID_W-1:0]   start_val_i,
    output logic [ID_W-1:0]   poll_addr_o,
    output logic              polling_o,
    output logic              grant_o,
    output logic [ID_W-1:0]   owner_o
);

    ctrl_cmd_t       cmd;
    arb_state_e      state;
    logic            last_step;
    logic [ID_W-1:0] start_id;
    logic [ID_W-1:0] cnt;

    pollarb_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .bus_req   (bus_req_i),
        .busy      (busy_i),
        .last_step (last_step),
        .cmd       (cmd),
        .state     (state)
    );

    pollarb_counter #(
        .N_DEV (N_DEV),
        .ID_W  (ID_W)
    ) u_counter (
        .clk       (clk),
        .rst       (rst),
        .launch    (cmd.launch),
        .advance   (cmd.advance),
        .start_id  (start_id),
        .cnt       (cnt),
        .last_step (last_step)
    );

    pollarb_start_sel #(
        .N_DEV (N_DEV),
        .ID_W  (ID_W)
    ) u_start (
        .clk         (clk),
        .rst         (rst),
        .mode        (start_mode_e'(mode_i)),
        .ld          (start_ld_i),
        .ld_val      (start_val_i),
        .win_capture (cmd.hit),
        .win_id      (cnt),
        .start_id    (start_id),
        .last_win    (owner_o)
    );

    assign poll_addr_o = cnt;
    assign polling_o   = (state == ST_POLL);
    assign grant_o     = (state == ST_GRANT);

endmodule

// File: rtl/pollarb_chk.sv
module pollarb_chk #(
    parameter int unsigned N_DEV = 6,
    parameter int unsigned ID_W  = 3
) (
    input logic            clk,
    input logic            rst,
    input logic            bus_req_i,
    input logic            busy_i,
    input logic [ID_W-1:0] poll_addr_o,
    input logic            polling_o,
    input logic            grant_o,
    input logic [ID_W-1:0] owner_o
);

    logic [ID_W-1:0] exp_next;
    int unsigned     run_cnt;

    assign exp_next = (32'(poll_addr_o) == N_DEV - 1) ? '0 : poll_addr_o + ID_W'(1);

    // Count of consecutive poll cycles before the current one
    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= 0;
        end else if (polling_o) begin
            run_cnt <= run_cnt + 1;
        end else begin
            run_cnt <= 0;
        end
    end

    // R2
    idle_launch_chk: assert property (@(posedge clk) disable iff (rst)
        (!polling_o && !grant_o && bus_req_i) |=> polling_o);

    // R2
    idle_stay_chk: assert property (@(posedge clk) disable iff (rst)
        (!polling_o && !grant_o && !bus_req_i) |=> !polling_o);

    // R6
    poll_step_chk: assert property (@(posedge clk) disable iff (rst)
        (polling_o && !busy_i) |=> (!polling_o || poll_addr_o == $past(exp_next)));

    // R7
    grant_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (polling_o && busy_i) |=> (grant_o && !polling_o && owner_o == $past(poll_addr_o)));

    // R7
    addr_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (grant_o && busy_i) |=> (grant_o && $stable(poll_addr_o)));

    // R8
    release_chk: assert property (@(posedge clk) disable iff (rst)
        (grant_o && !busy_i) |=> (!grant_o && !polling_o));

    // R9
    round_len_chk: assert property (@(posedge clk) disable iff (rst)
        polling_o |-> (run_cnt < N_DEV));

    // R10
    idle_no_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (!polling_o && !grant_o) |=> !grant_o);

    // R7
    phase_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(polling_o && grant_o));

endmodule

bind pollarb pollarb_chk #(
    .N_DEV (N_DEV),
    .ID_W  (ID_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_req_i   (bus_req_i),
    .busy_i      (busy_i),
    .poll_addr_o (poll_addr_o),
    .polling_o   (polling_o),
    .grant_o     (grant_o),
    .owner_o     (owner_o)
);

// File: tb/pollarb_tb.sv
`timescale 1ns/1ps
module pollarb_tb;

    localparam int N = 6;
    localparam int W = 3;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] dev_req = '0;
    logic         ghost = 1'b0;
    logic         hold = 1'b0;
    logic         busy_force = 1'b0;
    logic [1:0]   mode = 2'd0;
    logic         ld = 1'b0;
    logic [W-1:0] ld_val = '0;
    logic         bus_req;
    logic         busy;
    logic [W-1:0] addr;
    logic         pol;
    logic         gnt;
    logic [W-1:0] owner;

    int checks = 0;
    int errors = 0;
    int last_m = N - 1;
    int prog_m = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    assign bus_req = (|dev_req) | ghost;

    // Device model: the polled device answers if it requests; the owner holds busy
    always_comb begin
        busy = busy_force | (gnt & hold);
        if (pol && int'(addr) < N) busy = busy | dev_req[addr];
    end

    pollarb #(.N_DEV(N), .ID_W(W)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .bus_req_i   (bus_req),
        .busy_i      (busy),
        .mode_i      (mode),
        .start_ld_i  (ld),
        .start_val_i (ld_val),
        .poll_addr_o (addr),
        .polling_o   (pol),
        .grant_o     (gnt),
        .owner_o     (owner)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int start_of(input int md);
        case (md)
            1: return (last_m + 1) % N;
            2: return prog_m;
            default: return 0;
        endcase
    endfunction

    function automatic string start_tag(input int md);
        case (md)
            1: return "R4 rotating start";
            2: return "R5 programmed start";
            default: return "R3 fixed start";
        endcase
    endfunction

    task automatic load_start(input int v);
        ld     = 1'b1;
        ld_val = W'(v);
        @(negedge clk);
        ld     = 1'b0;
        prog_m = (v < N) ? v : 0;
    endtask

    // One round with a nonzero requester mask; called at a negedge while idle
    task automatic round(input logic [N-1:0] mask, input int md, input int holdn);
        int st, k, win;
        st = start_of(md);
        k = -1; win = 0;
        for (int i = 0; i < N; i++) begin
            if (k < 0 && mask[(st + i) % N]) begin
                k = i; win = (st + i) % N;
            end
        end
        mode = 2'(md); dev_req = mask; hold = 1'b1;
        @(negedge clk);
        chk(pol == 1'b1, "R2 polling after request", int'(pol), 1);
        chk(int'(addr) == st, start_tag(md), int'(addr), st);
        for (int i = 1; i <= k; i++) begin
            @(negedge clk);
            chk(int'(addr) == (st + i) % N, "R6 poll step", int'(addr), (st + i) % N);
        end
        @(negedge clk);
        chk(gnt == 1'b1 && pol == 1'b0, "R7 grant after busy", int'(gnt), 1);
        chk(int'(owner) == win, "R7 owner", int'(owner), win);
        last_m = win;
        for (int h = 0; h < holdn; h++) begin
            @(negedge clk);
            chk(gnt == 1'b1, "R8 grant held", int'(gnt), 1);
            chk(int'(addr) == win, "R7 address frozen", int'(addr), win);
        end
        hold = 1'b0; dev_req = '0;
        @(negedge clk);
        chk(gnt == 1'b0 && pol == 1'b0, "R8 release", int'(gnt), 0);
    endtask

    // Request line high but nobody answers
    task automatic empty_round(input int md);
        int st;
        st = start_of(md);
        mode = 2'(md); ghost = 1'b1;
        @(negedge clk);
        chk(int'(addr) == st, start_tag(md), int'(addr), st);
        for (int i = 1; i < N; i++) begin
            @(negedge clk);
            chk(pol == 1'b1 && int'(addr) == (st + i) % N, "R6 wrap in empty round",
                int'(addr), (st + i) % N);
        end
        @(negedge clk);
        chk(pol == 1'b0 && gnt == 1'b0, "R9 idle after full sweep", int'(pol), 0);
        ghost = 1'b0;
        @(negedge clk);
        chk(pol == 1'b0, "R9 polling ended", int'(pol), 0);
    endtask

    initial begin
        while (cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(pol == 1'b0 && gnt == 1'b0, "R1 reset idle", int'(pol), 0);
        chk(addr == '0, "R1 reset address", int'(addr), 0);

        // R2: idle with no request stays idle
        repeat (3) @(negedge clk);
        chk(pol == 1'b0, "R2 idle without request", int'(pol), 0);

        // R10: busy while idle is ignored
        busy_force = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(gnt == 1'b0 && pol == 1'b0, "R10 busy in idle", int'(gnt), 0);
        end
        busy_force = 1'b0;
        @(negedge clk);

        // R4 first rotating round after reset starts at 0
        round(6'b000100, 1, 1);
        round(6'b000001, 0, 2);        // R3 immediate hit at 0
        round(6'b100000, 0, 1);        // R3 walk to the last device
        round(6'b100001, 1, 1);        // R4 after winner 5 start wraps to 0
        round(6'b100001, 1, 1);        // R4 after winner 0 start is 1, wins 5
        round(6'b000001, 3, 1);        // R3 mode 3 acts as fixed
        load_start(4);
        round(6'b000010, 2, 3);        // R5 start 4, wraps to win 1
        load_start(7);
        round(6'b001000, 2, 1);        // R5 out-of-range value folds to 0
        empty_round(1);                // R9 rotation unchanged afterwards
        round(6'b111111, 1, 1);        // R4 rotating start after empty round
        empty_round(2);

        for (int r = 0; r < 40; r++) begin
            if ($urandom_range(0, 3) == 0) load_start(int'($urandom_range(0, 7)));
            round(N'($urandom_range(1, (1 << N) - 1)), int'($urandom_range(0, 3)),
                  int'($urandom_range(1, 4)));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule